// File: doc/BRIEF.md
# HDLC Transmit Framer with Zero Insertion

This block turns a stream of frame bytes into a synchronous serial HDLC bit stream. A byte source hands over bytes through a valid/ready handshake with an end-of-frame marker. The first bytes of each frame are the station address. There are zero, one or two of them, chosen by `addr_mode`. The control byte follows, then any information bytes. The block wraps these in an opening flag, a 16-bit frame check sequence and a closing flag. It moves one line bit for every cycle in which the physical layer raises `bit_en`.

Between the flags, any run of five consecutive ones is followed by an inserted zero. A flag pattern can therefore never appear inside a frame. The flags themselves are sent unaltered. While no frame is waiting, the line carries continuous flags. A frame whose first byte is already held when a flag completes starts straight after that flag, so the closing flag of one frame also serves as the opening flag of the next.

If the source has no byte ready at the end of a byte, the frame is closed at that point with its check sequence. Bytes that arrive later begin a new frame.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset, `tx_bit` is 1. With no frame pending, the line sends back-to-back flags of value 0x7E, least-significant bit first, one bit per `bit_en`.
- R2: A frame goes out in this order: opening flag, address bytes, control byte, information bytes, check sequence, closing flag. Every byte goes out least-significant bit first, in the order the bytes were accepted. `addr_mode` sets the address length: 0 gives no address, 1 gives one byte, and 2 or 3 give two bytes.
- R3: Between the flags, a 0 is inserted after every run of five consecutive 1 bits. The run is counted across byte boundaries and through the check sequence. A run of five ones that ends the check sequence also gets a zero before the closing flag. Flag bits are never stuffed.
- R4: The check sequence is a CRC-16 with polynomial x^16+x^12+x^5+1, processed least-significant bit first (reflected constant 0x8408) from a preset of 0xFFFF. It covers the unstuffed address, control and information bits. It is sent complemented, least-significant bit first.
- R5: An end marker on a byte placed before the control byte position is ignored, and the frame continues.
- R6: When the next frame's first byte is accepted before the closing flag completes, exactly one flag separates the two frames.
- R7: `in_ready` is 0 whenever the next line bit is an inserted zero. A byte is taken on a clock where `in_valid` and `in_ready` are both 1.
- R8: `tx_bit` changes only on clocks where `bit_en` is 1. `addr_mode` is sampled when a frame's first bit is about to be sent.
- R9: A frame may have an empty information field: the end marker on the control byte ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line bit strobe from the physical layer |
| addr_mode | input | 2 | Address length: 0 none, 1 one byte, 2/3 two bytes |
| in_valid | input | 1 | Source has a byte |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte ends the frame |
| in_ready | output | 1 | Framer accepts a byte this clock |
| tx_bit | output | 1 | Serial line bit |

## Verification
The hardest case to reach from the ports is a check sequence whose last five bits are ones, because that zero has to be inserted after the final check bit and just before the closing flag. The bench computes the CRC of candidate frames itself and searches for a control byte, or a control byte plus one information byte, that produces this tail, then sends that frame. Runs of ones that cross byte boundaries come from 0xFF and 0x7E data bytes, some of them sent under an irregular `bit_en` pattern. A second frame queued behind the first forces the shared flag.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [1:0] {
        PH_FLAG = 2'd0,
        PH_DATA = 2'd1,
        PH_FCS  = 2'd2,
        PH_TAIL = 2'd3
    } tx_phase_e;

    // byte position of the control field for a given address setting
    function automatic logic [1:0] ctrl_pos(input logic [1:0] mode);
        case (mode)
            2'd0:    ctrl_pos = 2'd0;
            2'd1:    ctrl_pos = 2'd1;
            default: ctrl_pos = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/hdlc_tx_hold.sv
module hdlc_tx_hold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              hold_off,
    input  logic              take,
    output logic              in_ready,
    output logic              full,
    output logic [BYTE_W-1:0] dout,
    output logic              dlast
);

    typedef struct packed {
        logic              full;
        logic [BYTE_W-1:0] data;
        logic              last;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d   = hold_q;
        in_ready = !hold_q.full && !hold_off;
        if (take) begin
            hold_d.full = 1'b0;
        end
        if (in_valid && in_ready) begin
            hold_d.full = 1'b1;
            hold_d.data = in_data;
            hold_d.last = in_last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign full  = hold_q.full;
    assign dout  = hold_q.data;
    assign dlast = hold_q.last;

    // R7
    held_byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q.full && !take) |=> (hold_q.full && $stable(hold_q.data) && $stable(hold_q.last)));

endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
    parameter int           CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h8408,
    parameter logic [CRC_W-1:0] INIT  = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             step,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);

    logic [CRC_W-1:0] crc_d, crc_q;
    logic             fb;

    always_comb begin
        crc_d = crc_q;
        fb    = crc_q[0] ^ din;
        if (init) begin
            crc_d = INIT;
        end else if (step) begin
            crc_d = {1'b0, crc_q[CRC_W-1:1]} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= INIT;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc = crc_q;

    // R4
    crc_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !step) |=> $stable(crc_q));

    // R4
    crc_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (crc_q == INIT));

endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
    import hdlc_tx_pkg::*;
#(
    parameter int              BYTE_W   = 8,
    parameter int              CRC_W    = 16,
    parameter int              RUN_MAX  = 5,
    parameter logic [BYTE_W-1:0] FLAG_PAT = 8'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [1:0]        addr_mode,
    input  logic              buf_full,
    input  logic [BYTE_W-1:0] buf_data,
    input  logic              buf_last,
    input  logic [CRC_W-1:0]  crc_val,
    output logic              take,
    output logic              stuff_pend,
    output logic              crc_init,
    output logic              crc_step,
    output logic              crc_bit,
    output logic              tx_bit
);

    localparam int BIT_W = $clog2(BYTE_W);
    localparam int CNT_W = $clog2(CRC_W);
    localparam int RUN_W = $clog2(RUN_MAX + 1);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FCS_END  = CNT_W'(CRC_W - 1);
    localparam logic [RUN_W-1:0] RUN_TOP  = RUN_W'(RUN_MAX);

    typedef struct packed {
        tx_phase_e         phase;
        logic [CNT_W-1:0]  cnt;
        logic [RUN_W-1:0]  ones;
        logic [BYTE_W-1:0] sh;
        logic              last_eff;
        logic [1:0]        idx;
        logic [1:0]        mode;
        logic              tx;
    } seq_t;

    seq_t seq_d, seq_q;
    logic data_bit;
    logic fcs_bit;
    logic [RUN_W-1:0] ones_nx;

    always_comb begin
        seq_d      = seq_q;
        take       = 1'b0;
        crc_init   = 1'b0;
        crc_step   = 1'b0;
        crc_bit    = 1'b0;
        stuff_pend = (seq_q.phase != PH_FLAG) && (seq_q.ones == RUN_TOP);
        data_bit   = seq_q.sh[seq_q.cnt[BIT_W-1:0]];
        fcs_bit    = ~crc_val[seq_q.cnt];
        ones_nx    = '0;

        if (bit_en) begin
            unique case (seq_q.phase)
                PH_FLAG: begin
                    seq_d.tx = FLAG_PAT[seq_q.cnt[BIT_W-1:0]];
                    if (seq_q.cnt == BYTE_END) begin
                        seq_d.cnt = '0;
                        if (buf_full) begin
                            take           = 1'b1;
                            crc_init       = 1'b1;
                            seq_d.phase    = PH_DATA;
                            seq_d.ones     = '0;
                            seq_d.sh       = buf_data;
                            seq_d.mode     = addr_mode;
                            seq_d.last_eff = buf_last && (ctrl_pos(addr_mode) == 2'd0);
                            seq_d.idx      = 2'd1;
                        end
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end

                PH_DATA: begin
                    if (stuff_pend) begin
                        seq_d.tx   = 1'b0;
                        seq_d.ones = '0;
                    end else begin
                        seq_d.tx   = data_bit;
                        seq_d.ones = data_bit ? seq_q.ones + 1'b1 : '0;
                        crc_step   = 1'b1;
                        crc_bit    = data_bit;
                        if (seq_q.cnt == BYTE_END) begin
                            seq_d.cnt = '0;
                            if (!seq_q.last_eff && buf_full) begin
                                take           = 1'b1;
                                seq_d.sh       = buf_data;
                                seq_d.last_eff = buf_last && (seq_q.idx >= ctrl_pos(seq_q.mode));
                                seq_d.idx      = (seq_q.idx == 2'd3) ? 2'd3 : seq_q.idx + 1'b1;
                            end else begin
                                seq_d.phase = PH_FCS;
                            end
                        end else begin
                            seq_d.cnt = seq_q.cnt + 1'b1;
                        end
                    end
                end

                PH_FCS: begin
                    if (stuff_pend) begin
                        seq_d.tx   = 1'b0;
                        seq_d.ones = '0;
                    end else begin
                        ones_nx    = fcs_bit ? seq_q.ones + 1'b1 : '0;
                        seq_d.tx   = fcs_bit;
                        seq_d.ones = ones_nx;
                        if (seq_q.cnt == FCS_END) begin
                            seq_d.cnt   = '0;
                            seq_d.phase = (ones_nx == RUN_TOP) ? PH_TAIL : PH_FLAG;
                        end else begin
                            seq_d.cnt = seq_q.cnt + 1'b1;
                        end
                    end
                end

                PH_TAIL: begin
                    seq_d.tx    = 1'b0;
                    seq_d.ones  = '0;
                    seq_d.cnt   = '0;
                    seq_d.phase = PH_FLAG;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.phase <= PH_FLAG;
            seq_q.tx    <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign tx_bit = seq_q.tx;

    // R3
    zero_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && seq_q.phase != PH_FLAG && seq_q.ones == RUN_TOP) |=> (tx_bit == 1'b0));

    // R3
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.ones <= RUN_TOP);

    // R8
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));

    // R5
    early_end_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_DATA && seq_q.idx <= ctrl_pos(seq_q.mode)) |-> !seq_q.last_eff);

    // R2
    take_only_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (bit_en && buf_full && seq_q.cnt == BYTE_END));

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
    parameter int                BYTE_W   = 8,
    parameter int                CRC_W    = 16,
    parameter int                RUN_MAX  = 5,
    parameter logic [BYTE_W-1:0] FLAG_PAT = 8'h7E,
    parameter logic [CRC_W-1:0]  CRC_POLY = 16'h8408,
    parameter logic [CRC_W-1:0]  CRC_INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [1:0]        addr_mode,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              tx_bit
);

    logic              take;
    logic              stuff_pend;
    logic              buf_full;
    logic [BYTE_W-1:0] buf_data;
    logic              buf_last;
    logic              crc_init;
    logic              crc_step;
    logic              crc_bit;
    logic [CRC_W-1:0]  crc_val;

    hdlc_tx_hold #(.BYTE_W(BYTE_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .hold_off (stuff_pend),
        .take     (take),
        .in_ready (in_ready),
        .full     (buf_full),
        .dout     (buf_data),
        .dlast    (buf_last)
    );

    hdlc_tx_fcs #(.CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_fcs (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .step  (crc_step),
        .din   (crc_bit),
        .crc   (crc_val)
    );

    hdlc_tx_seq #(
        .BYTE_W   (BYTE_W),
        .CRC_W    (CRC_W),
        .RUN_MAX  (RUN_MAX),
        .FLAG_PAT (FLAG_PAT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .addr_mode  (addr_mode),
        .buf_full   (buf_full),
        .buf_data   (buf_data),
        .buf_last   (buf_last),
        .crc_val    (crc_val),
        .take       (take),
        .stuff_pend (stuff_pend),
        .crc_init   (crc_init),
        .crc_step   (crc_step),
        .crc_bit    (crc_bit),
        .tx_bit     (tx_bit)
    );

    // R7
    ready_low_on_stuff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_pend |-> !in_ready);

    // R7
    no_take_and_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && in_valid && in_ready));

endmodule

// File: tb/tb_hdlc_tx_framer.sv
module tb_hdlc_tx_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [1:0] addr_mode = 2'd0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       tx_bit;

    always #5 clk = ~clk;

    hdlc_tx_framer dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .addr_mode(addr_mode),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .tx_bit(tx_bit)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // behavioural reference model state
    int  exp_q[$];
    int  acc_q[$];
    bit  in_frame = 0;
    int  run = 0;
    int  crc = 16'hFFFF;
    int  idx = 0;
    int  ctrl = 0;
    bit  last_eff = 0;
    int  frame_tag = 2;
    int  cur_tag = 2;
    bit  exp_line = 1;
    int  exp_tag = 1;
    bit  last_en = 0;
    int  b2b_at = -1;
    int  flags_since = 0;
    int  frames_done = 0;
    int  tail_stuffs = 0;
    bit  model_on = 0;
    int  en_mode = 3;

    function automatic string tag_s(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int crc_upd(int c, int b);
        int fb;
        fb = (c ^ b) & 1;
        c = c >> 1;
        if (fb != 0) c = c ^ 16'h8408;
        return c;
    endfunction

    function automatic void push_bit(int b, int tag, bit bnd);
        exp_q.push_back(b | (tag << 1) | (int'(bnd) << 5));
    endfunction

    function automatic void add_flag();
        for (int i = 0; i < 8; i++) push_bit((8'h7E >> i) & 1, 1, i == 7);
    endfunction

    function automatic void add_unit(int v, int nbits, int tag, bit is_data);
        for (int i = 0; i < nbits; i++) begin
            int b;
            b = (v >> i) & 1;
            push_bit(b, tag, is_data && (i == nbits - 1));
            if (is_data) crc = crc_upd(crc, b);
            run = (b != 0) ? run + 1 : 0;
            if (run == 5) begin
                push_bit(0, 3, 0);
                run = 0;
                if (!is_data && i == nbits - 1) tail_stuffs++;
            end
        end
    endfunction

    function automatic void take_byte();
        int e;
        e = acc_q.pop_front();
        last_eff = (((e >> 8) & 1) != 0) && (idx >= ctrl);
        idx++;
        add_unit(e & 255, 8, cur_tag, 1);
    endfunction

    task automatic on_boundary();
        if (!in_frame) begin
            flags_since++;
            if (acc_q.size() > 0) begin
                // R6: one shared flag between queued frames
                if (frames_done == b2b_at) chk(flags_since == 1, "R6", flags_since, 1);
                in_frame = 1;
                idx = 0;
                ctrl = (addr_mode == 2'd0) ? 0 : (addr_mode == 2'd1) ? 1 : 2;
                crc = 16'hFFFF;
                run = 0;
                cur_tag = frame_tag;
                take_byte();
            end else begin
                add_flag();
            end
        end else begin
            if (!last_eff && acc_q.size() > 0) begin
                take_byte();
            end else begin
                add_unit((~crc) & 16'hFFFF, 16, 4, 0);
                add_flag();
                in_frame = 0;
                frames_done++;
                flags_since = 0;
            end
        end
    endtask

    always @(negedge clk) begin
        if (model_on) begin
            chk(tx_bit == exp_line, last_en ? tag_s(exp_tag) : "R8", tx_bit, exp_line);
            if (exp_q.size() > 0 && ((exp_q[0] >> 1) & 15) == 3)
                chk(in_ready == 1'b0, "R7", in_ready, 0);
            if (bit_en) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2", 0, 1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    exp_line = e[0];
                    exp_tag = (e >> 1) & 15;
                    if (((e >> 5) & 1) != 0) on_boundary();
                end
            end
            last_en = bit_en;
            if (in_valid && in_ready) acc_q.push_back(int'(in_data) | (int'(in_last) << 8));
        end
    end

    // bit strobe pattern
    initial begin
        int ctr;
        ctr = 0;
        forever begin
            @(posedge clk);
            #1;
            ctr++;
            case (en_mode)
                0: bit_en = 1'b1;
                1: bit_en = ((ctr % 3) != 1) && ((ctr % 7) != 3);
                default: bit_en = 1'b0;
            endcase
        end
    end

    task automatic put(int b, bit l);
        in_valid = 1'b1;
        in_data = b[7:0];
        in_last = l;
        forever begin
            @(negedge clk);
            if (in_ready) begin
                @(posedge clk);
                #1;
                break;
            end
        end
        in_valid = 1'b0;
        in_last = 1'b0;
    endtask

    task automatic wait_idle();
        do @(posedge clk); while (in_frame || acc_q.size() != 0 || in_valid);
        repeat (90) @(posedge clk);
        #1;
    endtask

    function automatic bit tail_hit(int a, int b, int nb);
        int c, r, v, bt;
        c = 16'hFFFF;
        r = 0;
        for (int k = 0; k < nb; k++) begin
            v = (k == 0) ? a : b;
            for (int i = 0; i < 8; i++) begin
                bt = (v >> i) & 1;
                c = crc_upd(c, bt);
                r = (bt != 0) ? r + 1 : 0;
                if (r == 5) r = 0;
            end
        end
        v = (~c) & 16'hFFFF;
        for (int i = 0; i < 16; i++) begin
            bt = (v >> i) & 1;
            r = (bt != 0) ? r + 1 : 0;
            if (r == 5) begin
                if (i == 15) return 1;
                r = 0;
            end
        end
        return 0;
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R2 watchdog", 0, 1);
        summary();
    end

    initial begin
        int ta, tb_, tn;
        add_flag();
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_on = 1;
        @(negedge clk);
        #1;
        // R1 / R7 reset state
        chk(tx_bit == 1'b1, "R1", tx_bit, 1);
        chk(in_ready == 1'b1, "R7", in_ready, 1);
        @(posedge clk);
        #1;
        en_mode = 0;
        repeat (30) @(posedge clk);
        #1;

        // R2: one address byte, runs of ones in the information field
        frame_tag = 2;
        addr_mode = 2'd1;
        put(8'h03, 0); put(8'h3F, 0); put(8'h12, 0); put(8'hFF, 0); put(8'hFF, 0); put(8'hA5, 1);
        wait_idle();

        // R9: no address, control byte only
        frame_tag = 9;
        addr_mode = 2'd0;
        put(8'h93, 1);
        wait_idle();

        // R5: two address bytes, end marker on the first address byte ignored
        frame_tag = 5;
        addr_mode = 2'd2;
        put(8'hC1, 1); put(8'h7E, 0); put(8'h55, 0); put(8'hF8, 1);
        wait_idle();

        // R6: back-to-back frames share one flag
        frame_tag = 2;
        addr_mode = 2'd1;
        b2b_at = frames_done + 1;
        put(8'h01, 0); put(8'h10, 0); put(8'hAA, 1);
        put(8'h02, 0); put(8'h11, 0); put(8'hBB, 0); put(8'hCC, 1);
        wait_idle();
        b2b_at = -1;

        // R8: irregular bit strobe, ones runs across byte boundaries
        en_mode = 1;
        addr_mode = 2'd3;
        put(8'hFF, 0); put(8'hFF, 0); put(8'hFF, 0); put(8'h00, 1);
        wait_idle();
        en_mode = 0;

        // R3: frame whose check sequence ends in five ones
        tn = 0;
        for (int a = 0; a < 256 && tn == 0; a++) begin
            if (tail_hit(a, 0, 1)) begin ta = a; tb_ = 0; tn = 1; end
            for (int b = 0; b < 256 && tn == 0; b++)
                if (tail_hit(a, b, 2)) begin ta = a; tb_ = b; tn = 2; end
        end
        chk(tn != 0, "R3", tn, 1);
        frame_tag = 2;
        addr_mode = 2'd0;
        if (tn == 1) put(ta, 1);
        else if (tn == 2) begin put(ta, 0); put(tb_, 1); end
        wait_idle();
        chk(tail_stuffs > 0, "R3", tail_stuffs, 1);

        chk(frames_done == 7, "R2", frames_done, 7);
        chk(exp_q.size() <= 16, "R1", exp_q.size(), 8);
        summary();
    end

endmodule